// File: doc/BRIEF.md
# Exception and Interrupt Sequencer

This block decides, one clock at a time, whether the processor leaves its normal flow for an exception. It weighs a 5-bit interrupt request mask against the processor status word (PSW), accepts trap requests carrying a 5-bit code, and tracks a halt state that only an accepted interrupt can end. When an entry is taken, the block forms a cause code, fills the save registers of the proper tier, produces the updated PSW, and emits a one-cycle redirect with the fetch vector. The core owns the PSW register: it drives the PSW into `psw_in` and loads `psw_out` whenever `redirect_o` pulses.

Exceptions nest in three tiers. With no exception pending, an entry is a regular one and sets the exception-pending bit. With exception-pending already set, the entry is duplexed: it uses a second set of save registers and sets the NMI-pending bit. With NMI-pending already set, the entry is fatal. The block then dumps a marker word, the PSW and the PC to addresses 0, 4 and 8 over a valid/ready write port and locks up for good.

Top module: `exc_sequencer`

## Requirements
- R1: After reset `next_pc_o` is 0xFFFFFFF0, `exc_cause_o` is 0xFFF0, `dup_cause_o` is 0x0000, and `halted_o`, `locked_o`, `redirect_o` and `mem_valid_o` are all 0.
- R2: The interrupt level is the index of the highest set bit of `irq_req`, from 0 to 4. An all-zero mask causes no entry.
- R3: An interrupt is accepted only when PSW bits 12 (interrupt disable), 14 (exception pending) and 15 (NMI pending) are all clear and its level is at least the mask level in PSW bits 19:16. Otherwise it causes no entry.
- R4: An interrupt gives cause 0xFE00 | (level << 4), and a trap gives cause 0xFFA0 + `trap_code`. When an interrupt is accepted in the same cycle as a trap request, the interrupt wins.
- R5: On a regular entry (PSW bits 14 and 15 clear), `exc_cause_o`, `exc_psw_o` and `exc_pc_o` take the cause, `psw_in` and the PC. `psw_out` has bit 14 set, and `next_pc_o` is 0xFFFF0000 | (cause & 0xFFF0), where any cause 0xFF6x maps to 0xFFFFFF60.
- R6: On a duplexed entry (bit 14 set, bit 15 clear), `dup_cause_o`, `dup_psw_o` and `dup_pc_o` take the cause, `psw_in` and `pc_in`. `psw_out` has bit 15 set, `next_pc_o` is 0xFFFFFFD0, and the regular save registers stay as they were.
- R7: A regular interrupt entry sets PSW bits 19:16 of `psw_out` to the level plus one. A trap entry leaves them unchanged.
- R8: Every non-fatal entry yields a `psw_out` with bit 13 (address trap enable) cleared and bit 12 set. All other bits not named in R5 to R7 are copied from `psw_in`.
- R9: The redirect and all register updates appear in the cycle after the edge that samples the request. `redirect_o` lasts exactly one cycle.
- R10: `halt_req` with no accepted interrupt and no trap sets `halted_o`. While halted, traps and halt requests are ignored. An accepted interrupt clears `halted_o` and saves `pc_in` + 2 as the exception PC.
- R11: A fatal entry (bit 15 set) writes 0xFFFF0000 | cause to address 0, then `psw_in` to 4, then `pc_in` to 8. Each write holds its address and data until `mem_ready` is seen high.
- R12: After the third write is accepted, `locked_o` and `halted_o` are 1 for good. All requests are then ignored, and no redirect is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 5 | Interrupt request mask |
| trap_req | input | 1 | Trap instruction request |
| trap_code | input | 5 | Trap immediate |
| halt_req | input | 1 | Halt instruction request |
| pc_in | input | 32 | PC of the current instruction |
| psw_in | input | 32 | Current PSW |
| redirect_o | output | 1 | One-cycle pulse: load `next_pc_o` and `psw_out` |
| next_pc_o | output | 32 | Fetch vector |
| psw_out | output | 32 | Updated PSW |
| exc_cause_o | output | 16 | Regular-tier cause |
| exc_psw_o | output | 32 | Regular-tier saved PSW |
| exc_pc_o | output | 32 | Regular-tier saved PC |
| dup_cause_o | output | 16 | Duplexed-tier cause |
| dup_psw_o | output | 32 | Duplexed-tier saved PSW |
| dup_pc_o | output | 32 | Duplexed-tier saved PC |
| halted_o | output | 1 | Halt state |
| locked_o | output | 1 | Permanent fatal lock |
| mem_valid_o | output | 1 | Dump write valid |
| mem_addr_o | output | 32 | Dump write address |
| mem_wdata_o | output | 32 | Dump write data |
| mem_ready | input | 1 | Dump write accepted |

## Verification
Acceptance is swept over every one of the 32 request masks, every mask level from 0 to 5 and all eight combinations of the three blocking PSW bits. This separates the highest-bit level choice from the level comparison and from each blocking bit. The PSW given to accepted cases has bit 13 set and stray low bits set, so the clearing of bit 13 and the copying of untouched bits can be seen. All 32 trap codes are run in both the regular and the duplexed tier, which shows whether the cause, the vector and the choice of save-register set stay separate. Directed sequences cover interrupt-over-trap priority, halt entry with an ignored trap followed by a wake-up that adds 2 to the saved PC, and a fatal dump in which `mem_ready` is held low between writes before the lock is checked.

// File: rtl/exc_sequencer.sv
module exc_sequencer #(
  parameter int NIRQ = 5,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            trap_req,
  input  logic [4:0]      trap_code,
  input  logic            halt_req,
  input  logic [XLEN-1:0] pc_in,
  input  logic [31:0]     psw_in,
  output logic            redirect_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [31:0]     psw_out,
  output logic [15:0]     exc_cause_o,
  output logic [31:0]     exc_psw_o,
  output logic [XLEN-1:0] exc_pc_o,
  output logic [15:0]     dup_cause_o,
  output logic [31:0]     dup_psw_o,
  output logic [XLEN-1:0] dup_pc_o,
  output logic            halted_o,
  output logic            locked_o,
  output logic            mem_valid_o,
  output logic [31:0]     mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_ready
);
  localparam int LW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam int B_ID = 12, B_AE = 13, B_EP = 14, B_NP = 15, B_LV = 16;

  typedef enum logic [1:0] {S_RUN, S_DUMP, S_LOCK} state_t;
  state_t state;

  logic [LW-1:0]   lvl;
  logic [3:0]      lvl4;
  logic            irq_take, trap_take, halt_take, enter;
  logic [15:0]     cause;
  logic [31:0]     psw_new, vec;
  logic [XLEN-1:0] save_pc;
  logic [1:0]      dump_idx;
  logic [31:0]     dump_w0, dump_w1, dump_w2;

  always_comb begin
    lvl = '0;
    for (int i = 0; i < NIRQ; i++)
      if (irq_req[i]) lvl = LW'(i);
  end
  assign lvl4 = 4'(lvl);

  assign irq_take  = (state == S_RUN) && (|irq_req) &&
                     !psw_in[B_ID] && !psw_in[B_EP] && !psw_in[B_NP] &&
                     (lvl4 >= psw_in[B_LV +: 4]);
  assign trap_take = (state == S_RUN) && !halted_o && !irq_take && trap_req;
  assign halt_take = (state == S_RUN) && !halted_o && !irq_take && !trap_req && halt_req;
  assign enter     = irq_take || trap_take;

  assign cause   = irq_take ? (16'hFE00 | (16'(lvl4) << 4)) : (16'hFFA0 + {11'b0, trap_code});
  assign save_pc = pc_in + ((irq_take && halted_o) ? XLEN'(2) : XLEN'(0));
  assign vec     = (cause[15:4] == 12'hFF6) ? 32'hFFFFFF60 : {16'hFFFF, cause[15:4], 4'h0};

  always_comb begin
    psw_new       = psw_in;
    psw_new[B_AE] = 1'b0;
    psw_new[B_ID] = 1'b1;
    if (psw_in[B_EP]) psw_new[B_NP] = 1'b1;
    else begin
      psw_new[B_EP] = 1'b1;
      if (irq_take) psw_new[B_LV +: 4] = lvl4 + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_RUN;
      redirect_o  <= 1'b0;
      next_pc_o   <= XLEN'(32'hFFFFFFF0);
      psw_out     <= '0;
      exc_cause_o <= 16'hFFF0;
      exc_psw_o   <= '0;
      exc_pc_o    <= '0;
      dup_cause_o <= '0;
      dup_psw_o   <= '0;
      dup_pc_o    <= '0;
      halted_o    <= 1'b0;
      dump_idx    <= '0;
      dump_w0     <= '0;
      dump_w1     <= '0;
      dump_w2     <= '0;
    end else begin
      redirect_o <= 1'b0;
      case (state)
        S_RUN: begin
          if (enter && psw_in[B_NP]) begin
            state    <= S_DUMP;
            dump_idx <= '0;
            dump_w0  <= 32'hFFFF0000 | {16'h0, cause};
            dump_w1  <= psw_in;
            dump_w2  <= 32'(pc_in);
          end else if (enter) begin
            redirect_o <= 1'b1;
            psw_out    <= psw_new;
            if (irq_take) halted_o <= 1'b0;
            if (psw_in[B_EP]) begin
              dup_cause_o <= cause;
              dup_psw_o   <= psw_in;
              dup_pc_o    <= pc_in;
              next_pc_o   <= XLEN'(32'hFFFFFFD0);
            end else begin
              exc_cause_o <= cause;
              exc_psw_o   <= psw_in;
              exc_pc_o    <= save_pc;
              next_pc_o   <= XLEN'(vec);
            end
          end else if (halt_take) begin
            halted_o <= 1'b1;
          end
        end
        S_DUMP: begin
          if (mem_ready) begin
            dump_idx <= dump_idx + 2'd1;
            if (dump_idx == 2'd2) begin
              state    <= S_LOCK;
              halted_o <= 1'b1;
            end
          end
        end
        default: state <= S_LOCK;
      endcase
    end
  end

  assign locked_o    = (state == S_LOCK);
  assign mem_valid_o = (state == S_DUMP);
  assign mem_addr_o  = {28'h0, dump_idx, 2'b00};
  assign mem_wdata_o = (dump_idx == 2'd0) ? dump_w0 : (dump_idx == 2'd1) ? dump_w1 : dump_w2;
endmodule

module exc_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        redirect_o,
  input logic [31:0] psw_out,
  input logic        halted_o,
  input logic        locked_o,
  input logic        mem_valid_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ready
);
  a_r11_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_wdata_o));
  a_r12_lock_stays: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o && halted_o && !redirect_o);
  a_r8_psw_bits: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> psw_out[12] && !psw_out[13]);
  a_r10_wake_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted_o) |-> redirect_o);
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> !redirect_o && !locked_o);
endmodule

bind exc_sequencer exc_sequencer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .redirect_o(redirect_o), .psw_out(psw_out),
  .halted_o(halted_o), .locked_o(locked_o), .mem_valid_o(mem_valid_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready(mem_ready)
);

// File: tb/test_exc_sequencer.sv
module test_exc_sequencer;
  logic clk = 0, rst_n = 0;
  logic [4:0] irq_req = 0;
  logic trap_req = 0, halt_req = 0, mem_ready = 0;
  logic [4:0] trap_code = 0;
  logic [31:0] pc_in = 0, psw_in = 0;
  logic redirect_o, halted_o, locked_o, mem_valid_o;
  logic [31:0] next_pc_o, psw_out, exc_psw_o, exc_pc_o, dup_psw_o, dup_pc_o, mem_addr_o, mem_wdata_o;
  logic [15:0] exc_cause_o, dup_cause_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_sequencer i_exc_sequencer (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic clear_in();
    irq_req = 0; trap_req = 0; halt_req = 0; trap_code = 0;
  endtask

  function automatic logic [31:0] exp_psw(logic [31:0] p, bit is_irq, int lv);
    logic [31:0] r = p;
    r[13] = 0; r[12] = 1;
    if (p[14]) r[15] = 1;
    else begin
      r[14] = 1;
      if (is_irq) r[19:16] = 4'(lv + 1);
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] keep;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 next_pc", next_pc_o, 32'hFFFFFFF0);
    chk("R1 exc_cause", 32'(exc_cause_o), 32'h0000FFF0);
    chk("R1 dup_cause", 32'(dup_cause_o), 0);
    chk("R1 flags", {28'h0, halted_o, locked_o, redirect_o, mem_valid_o}, 0);

    for (int m = 0; m < 32; m++)
      for (int ml = 0; ml < 6; ml++)
        for (int f = 0; f < 8; f++) begin
          int lv;
          bit acc;
          logic [16:0] cs;
          lv = (m == 0) ? -1 : $clog2(m + 1) - 1;
          psw_in = 32'h0000_2005 | (32'(ml) << 16) | (32'(f[0]) << 12) | (32'(f[1]) << 14) | (32'(f[2]) << 15);
          pc_in = 32'h0100_0000 + 32'(m * 64 + ml * 8 + f);
          irq_req = 5'(m);
          @(negedge clk);
          acc = (m != 0) && (f == 0) && (lv >= ml);
          chk("R2 R3 acceptance", 32'(redirect_o), 32'(acc));
          if (acc) begin
            cs = 17'h0FE00 | 17'(lv << 4);
            chk("R4 irq cause", 32'(exc_cause_o), 32'(cs[15:0]));
            chk("R5 irq vector", next_pc_o, 32'hFFFF0000 | 32'(cs[15:0] & 16'hFFF0));
            chk("R5 saved pc", exc_pc_o, pc_in);
            chk("R5 saved psw", exc_psw_o, psw_in);
            chk("R7 R8 psw_out", psw_out, exp_psw(psw_in, 1, lv));
          end
          clear_in();
        end

    for (int c = 0; c < 32; c++) begin
      logic [15:0] cs;
      cs = 16'hFFA0 + 16'(c);
      psw_in = 32'h0003_2001;
      pc_in = 32'h2000_0000 + 32'(c);
      trap_req = 1; trap_code = 5'(c);
      @(negedge clk);
      chk("R9 redirect", 32'(redirect_o), 1);
      chk("R4 trap cause", 32'(exc_cause_o), 32'(cs));
      chk("R5 trap vector", next_pc_o, {16'hFFFF, cs & 16'hFFF0});
      chk("R7 R8 trap psw", psw_out, exp_psw(psw_in, 0, 0));
      clear_in();
      @(negedge clk);
      chk("R9 pulse", 32'(redirect_o), 0);
    end

    keep = exc_cause_o;
    for (int c = 0; c < 32; c++) begin
      psw_in = 32'h0000_6000 | 32'(c);
      pc_in = 32'h3000_0000 + 32'(c);
      trap_req = 1; trap_code = 5'(c);
      @(negedge clk);
      chk("R6 dup cause", 32'(dup_cause_o), 32'(16'hFFA0 + 16'(c)));
      chk("R6 dup vector", next_pc_o, 32'hFFFFFFD0);
      chk("R6 dup psw/pc", dup_psw_o ^ dup_pc_o, psw_in ^ pc_in);
      chk("R6 regular untouched", 32'(exc_cause_o), 32'(keep));
      chk("R8 dup psw_out", psw_out, exp_psw(psw_in, 0, 0));
      clear_in();
    end

    psw_in = 0; pc_in = 32'h0000_0040;
    irq_req = 5'b00010; trap_req = 1; trap_code = 5'd9;
    @(negedge clk);
    chk("R4 priority", 32'(exc_cause_o), 32'h0000FE10);
    clear_in();

    pc_in = 32'h0000_1234;
    halt_req = 1;
    @(negedge clk);
    chk("R10 halt set", {31'h0, halted_o}, 1);
    chk("R10 no redirect", 32'(redirect_o), 0);
    clear_in();
    keep = exc_cause_o;
    trap_req = 1; trap_code = 5'd3;
    @(negedge clk);
    chk("R10 trap ignored", {30'h0, redirect_o, halted_o}, 1);
    chk("R10 cause kept", 32'(exc_cause_o), 32'(keep));
    clear_in();
    irq_req = 5'b00100;
    @(negedge clk);
    chk("R10 wake", {30'h0, redirect_o, halted_o}, 2);
    chk("R10 pc+2", exc_pc_o, 32'h0000_1236);
    chk("R10 vector", next_pc_o, 32'hFFFFFE20);
    chk("R7 level", 32'(psw_out[19:16]), 3);
    clear_in();

    psw_in = 32'h0000_C005; pc_in = 32'hABCD_0000;
    trap_req = 1; trap_code = 5'd7;
    @(negedge clk);
    clear_in();
    for (int k = 0; k < 3; k++) begin
      logic [31:0] wd;
      wd = (k == 0) ? 32'hFFFFFFA7 : (k == 1) ? 32'h0000_C005 : 32'hABCD_0000;
      for (int s = 0; s < 2; s++) begin
        chk("R11 valid held", 32'(mem_valid_o), 1);
        chk("R11 addr", mem_addr_o, 32'(k * 4));
        chk("R11 data", mem_wdata_o, wd);
        @(negedge clk);
      end
      chk("R12 not locked early", 32'(locked_o), 0);
      mem_ready = 1;
      @(negedge clk);
      mem_ready = 0;
    end
    chk("R12 locked", {29'h0, locked_o, halted_o, mem_valid_o}, 6);
    psw_in = 0; irq_req = 5'b10000; trap_req = 1;
    @(negedge clk);
    chk("R12 ignored", {30'h0, redirect_o, locked_o}, 1);
    clear_in();
    @(negedge clk);
    chk("R12 still locked", {30'h0, locked_o, halted_o}, 3);

    finish_run();
  end
endmodule